// File: doc/BRIEF.md
# Program Flow Sequencer

This block decides the next program counter value for control-transfer operations. It can step to the following instruction, jump to a target, jump to the address held in the H-L register pair, call a subroutine, return from one, or restart to a fixed low vector. Jumps, calls and returns can be made conditional on one of eight flag tests. A condition that fails simply advances the program counter.

Calls and restarts save the return address on a byte-wide stack in memory, and returns restore it. The block addresses that stack with a 16-bit stack pointer and drives a byte memory port. Writes to the memory are synchronous. Read data must be valid in the same cycle as the address. Each stack byte takes one cycle, so a taken call, restart or return holds `busy` for exactly two cycles. Fetch and decode sit outside the block. The decoder supplies the operation kind, the condition select, the flags, the operand addresses and the address of the next sequential instruction. It offers an operation with `opValid`.

Top module: `flow_seq`

## Requirements
- R1: While reset is held and right after it, `pc` is 0x0000, `sp` is SP_INIT (default 0xF000), `busy` is 0, and `memWe` and `memRe` are 0.
- R2: An accepted step operation (opKind 0) loads `pc` with `nextPc` at the next clock edge.
- R3: An accepted jump (opKind 1) loads `target` into `pc` at the next edge when `useCond` is 0 or the selected condition holds. Otherwise it loads `nextPc`. Neither case uses the stack.
- R4: Condition select encoding, with flagP=1 meaning even parity: 000 zero clear, 001 zero set, 010 carry clear, 011 carry set, 100 odd parity, 101 even parity, 110 sign clear (plus), 111 sign set (minus).
- R5: A taken call (opKind 2) holds `busy` for two cycles after acceptance. In the first of these cycles it writes `nextPc[15:8]` to address sp-1. In the second it writes `nextPc[7:0]` to address sp-2.
- R6: At the edge that ends a taken call, `pc` becomes `target` and `sp` drops by 2.
- R7: A taken return (opKind 3) holds `busy` for two cycles. It reads the low byte at `sp`, then the high byte at sp+1. At the final edge `pc` becomes {high, low} and `sp` rises by 2.
- R8: A restart (opKind 4) is an unconditional call whose target is `rstNum`*8, so the vectors run from 0x0000 to 0x0038.
- R9: An H-L jump (opKind 5) loads `hlValue` into `pc` at the next edge whatever `useCond` says: H goes to the high byte and L to the low byte.
- R10: `opValid` is ignored while `busy` is 1.
- R11: A conditional call or return whose condition fails makes no memory access, leaves `sp` unchanged, keeps `busy` at 0 and loads `nextPc` into `pc` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered this cycle |
| opKind | input | 3 | 0 step, 1 jump, 2 call, 3 return, 4 restart, 5 H-L jump |
| useCond | input | 1 | Make a jump, call or return conditional |
| condSel | input | 3 | Condition select (R4) |
| flagZ | input | 1 | Zero flag |
| flagCy | input | 1 | Carry flag |
| flagS | input | 1 | Sign flag |
| flagP | input | 1 | Parity flag, 1 = even |
| target | input | 16 | Jump or call target address |
| rstNum | input | 3 | Restart number |
| hlValue | input | 16 | H-L pair value |
| nextPc | input | 16 | Address of the next sequential instruction |
| memRdData | input | 8 | Stack read data, valid in the same cycle as the address |
| memAddr | output | 16 | Stack byte address |
| memWe | output | 1 | Stack write strobe |
| memRe | output | 1 | Stack read strobe |
| memWrData | output | 8 | Stack write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Stack transfer in progress |

## Verification
Step, jump and H-L jump results appear on `pc` one edge after acceptance. The bench drives each operation at a falling edge and reads `pc` at the next falling edge. For calls, restarts and returns, the bench checks the memory strobe, address and data at each of the two falling edges after acceptance. It checks `pc`, `sp` and `busy` at the third falling edge, once the final register update has landed. To exercise R10, `opValid` is held with a conflicting jump during these busy cycles. A bench memory model answers reads in the same cycle, so a return reads back exactly the bytes that an earlier call stored.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam logic [2:0] OP_STEP  = 3'd0;
  localparam logic [2:0] OP_JUMP  = 3'd1;
  localparam logic [2:0] OP_CALL  = 3'd2;
  localparam logic [2:0] OP_RET   = 3'd3;
  localparam logic [2:0] OP_RST   = 3'd4;
  localparam logic [2:0] OP_HLJMP = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_POP_LO, ST_POP_HI
  } seqState_e;

  typedef struct packed {
    logic pcStep;
    logic pcJump;
    logic pcHl;
    logic capture;
    logic captureRst;
    logic pushHi;
    logic pushLo;
    logic popLo;
    logic popHi;
  } strobe_t;
endpackage

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic       useCond,
  input  logic [2:0] condSel,
  input  logic       flagZ,
  input  logic       flagCy,
  input  logic       flagS,
  input  logic       flagP,
  output strobe_t    strobe,
  output logic       busy
);
  seqState_e state, stateNxt;
  logic condTrue, condOk;

  // condition select: bit 0 picks the polarity, bits 2:1 pick the flag
  always_comb begin
    case (condSel[2:1])
      2'd0:    condTrue = flagZ;
      2'd1:    condTrue = flagCy;
      2'd2:    condTrue = flagP;
      default: condTrue = flagS;
    endcase
    if (!condSel[0]) condTrue = !condTrue;
  end

  assign condOk = !useCond || condTrue;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (opValid) begin
          case (opKind)
            OP_JUMP: begin
              if (condOk) strobe.pcJump = 1'b1;
              else        strobe.pcStep = 1'b1;
            end
            OP_CALL: begin
              if (condOk) begin
                strobe.capture = 1'b1;
                stateNxt       = ST_PUSH_HI;
              end else begin
                strobe.pcStep = 1'b1;
              end
            end
            OP_RET: begin
              if (condOk) stateNxt = ST_POP_LO;
              else        strobe.pcStep = 1'b1;
            end
            OP_RST: begin
              strobe.capture    = 1'b1;
              strobe.captureRst = 1'b1;
              stateNxt          = ST_PUSH_HI;
            end
            OP_HLJMP: strobe.pcHl   = 1'b1;
            default:  strobe.pcStep = 1'b1;
          endcase
        end
      end
      ST_PUSH_HI: begin
        strobe.pushHi = 1'b1;
        stateNxt      = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        strobe.pushLo = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_POP_LO: begin
        strobe.popLo = 1'b1;
        stateNxt     = ST_POP_HI;
      end
      ST_POP_HI: begin
        strobe.popHi = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/flow_dp.sv
module flow_dp
  import flow_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          VEC_STEP = 8,
  parameter int          NUM_W    = 3,
  parameter logic [15:0] SP_INIT  = 16'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] target,
  input  logic [NUM_W-1:0]  rstNum,
  input  logic [ADDR_W-1:0] hlValue,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [7:0]        memWrData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);
  localparam int VEC_SHIFT = $clog2(VEC_STEP);
  localparam int PAD_W     = ADDR_W - NUM_W - VEC_SHIFT;
  localparam int BYTE_W    = 8;

  logic [ADDR_W-1:0] tgtReg, retReg, rstVec;
  logic [BYTE_W-1:0] lowByte;

  assign rstVec = {{PAD_W{1'b0}}, rstNum, {VEC_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      sp      <= SP_INIT[ADDR_W-1:0];
      tgtReg  <= '0;
      retReg  <= '0;
      lowByte <= '0;
    end else begin
      if (strobe.capture) begin
        tgtReg <= strobe.captureRst ? rstVec : target;
        retReg <= nextPc;
      end
      if (strobe.pcStep) pc <= nextPc;
      if (strobe.pcJump) pc <= target;
      if (strobe.pcHl)   pc <= hlValue;
      if (strobe.pushLo) begin
        pc <= tgtReg;
        sp <= sp - ADDR_W'(2);
      end
      if (strobe.popLo) lowByte <= memRdData;
      if (strobe.popHi) begin
        pc <= {memRdData, lowByte};
        sp <= sp + ADDR_W'(2);
      end
    end
  end

  always_comb begin
    if (strobe.pushHi)      memAddr = sp - ADDR_W'(1);
    else if (strobe.pushLo) memAddr = sp - ADDR_W'(2);
    else if (strobe.popHi)  memAddr = sp + ADDR_W'(1);
    else                    memAddr = sp;
  end

  assign memWe     = strobe.pushHi | strobe.pushLo;
  assign memRe     = strobe.popLo | strobe.popHi;
  assign memWrData = strobe.pushHi ? retReg[ADDR_W-1:ADDR_W-BYTE_W] : retReg[BYTE_W-1:0];
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter logic [15:0] SP_INIT = 16'hF000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opKind,
  input  logic        useCond,
  input  logic [2:0]  condSel,
  input  logic        flagZ,
  input  logic        flagCy,
  input  logic        flagS,
  input  logic        flagP,
  input  logic [15:0] target,
  input  logic [2:0]  rstNum,
  input  logic [15:0] hlValue,
  input  logic [15:0] nextPc,
  input  logic [7:0]  memRdData,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic        memRe,
  output logic [7:0]  memWrData,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        busy
);
  strobe_t strobe;

  flow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .useCond(useCond), .condSel(condSel), .flagZ(flagZ), .flagCy(flagCy),
    .flagS(flagS), .flagP(flagP), .strobe(strobe), .busy(busy)
  );

  flow_dp #(.ADDR_W(16), .VEC_STEP(8), .NUM_W(3), .SP_INIT(SP_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .target(target),
    .rstNum(rstNum), .hlValue(hlValue), .nextPc(nextPc),
    .memRdData(memRdData), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWrData(memWrData), .pc(pc), .sp(sp)
  );
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] memAddr,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] sp,
  input logic        busy
);
  // R5, R7: a stack transfer lasts exactly two busy cycles
  p_busy_two_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 !busy);

  // R5: memory strobes only while busy
  p_mem_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> busy);

  // R5: the second push byte sits one below the first
  p_push_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr == $past(memAddr) - 16'd1);

  // R7: the second pop byte sits one above the first
  p_pop_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> memAddr == $past(memAddr) + 16'd1);

  // R6: a finished push lowers sp by two
  p_call_sp_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(memWe)) |-> sp == $past(sp) - 16'd2);

  // R7: a finished pop raises sp by two
  p_ret_sp_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(memRe)) |-> sp == $past(sp) + 16'd2);

  // R11: sp does not move outside stack transfers
  p_sp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(sp));

  // R1: the memory port never reads and writes at once
  p_no_rw_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
endmodule

bind flow_seq flow_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe),
  .memRe(memRe), .sp(sp), .busy(busy)
);

// File: tb/flow_seq_test.sv
module flow_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opKind;
  logic        useCond;
  logic [2:0]  condSel;
  logic        flagZ, flagCy, flagS, flagP;
  logic [15:0] target, hlValue, nextPc;
  logic [2:0]  rstNum;
  logic [7:0]  memRdData;
  logic [15:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWrData;
  logic [15:0] pc, sp;
  logic        busy;

  int total = 0;
  int fails = 0;

  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRdData = mem[memAddr[7:0]];
  always @(posedge clk) if (memWe) mem[memAddr[7:0]] <= memWrData;

  flow_seq uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .useCond(useCond), .condSel(condSel), .flagZ(flagZ), .flagCy(flagCy),
    .flagS(flagS), .flagP(flagP), .target(target), .rstNum(rstNum),
    .hlValue(hlValue), .nextPc(nextPc), .memRdData(memRdData),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWrData(memWrData),
    .pc(pc), .sp(sp), .busy(busy)
  );

  // kind, useCond, cond, flags {z,cy,s,p}, target, nextPc, hl, expected pc
  typedef struct packed {
    logic [2:0]  kind;
    logic        uc;
    logic [2:0]  cond;
    logic [3:0]  flg;
    logic [15:0] tgt;
    logic [15:0] nxt;
    logic [15:0] hl;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 3'd0, 4'b0000, 16'h1111, 16'h0003, 16'h0000, 16'h0003}, // R2
    '{3'd1, 1'b0, 3'd0, 4'b0000, 16'h4000, 16'h0006, 16'h0000, 16'h4000}, // R3
    '{3'd1, 1'b1, 3'd0, 4'b1000, 16'h9999, 16'h4003, 16'h0000, 16'h4003}, // R4 NZ fail
    '{3'd1, 1'b1, 3'd1, 4'b1000, 16'h5000, 16'h4006, 16'h0000, 16'h5000}, // R4 Z
    '{3'd1, 1'b1, 3'd2, 4'b0000, 16'h5100, 16'h5003, 16'h0000, 16'h5100}, // R4 NC
    '{3'd1, 1'b1, 3'd3, 4'b0000, 16'h9999, 16'h5103, 16'h0000, 16'h5103}, // R4 C fail
    '{3'd1, 1'b1, 3'd4, 4'b0000, 16'h6000, 16'h5106, 16'h0000, 16'h6000}, // R4 PO
    '{3'd1, 1'b1, 3'd5, 4'b0000, 16'h9999, 16'h6003, 16'h0000, 16'h6003}, // R4 PE fail
    '{3'd1, 1'b1, 3'd6, 4'b0010, 16'h9999, 16'h6006, 16'h0000, 16'h6006}, // R4 P fail
    '{3'd1, 1'b1, 3'd7, 4'b0010, 16'h7000, 16'h6009, 16'h0000, 16'h7000}, // R4 M
    '{3'd5, 1'b0, 3'd0, 4'b0000, 16'h9999, 16'h7003, 16'hABCD, 16'hABCD}, // R9
    '{3'd5, 1'b1, 3'd1, 4'b0000, 16'h9999, 16'hABD0, 16'h1234, 16'h1234}  // R9 ignores cond
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setOp(input logic [2:0] k, input logic uc, input logic [2:0] c,
                       input logic [3:0] f, input logic [15:0] t, input logic [15:0] n,
                       input logic [15:0] h, input logic [2:0] r);
    opValid = 1'b1; opKind = k; useCond = uc; condSel = c;
    {flagZ, flagCy, flagS, flagP} = f;
    target = t; nextPc = n; hlValue = h; rstNum = r;
  endtask

  // Taken call or restart starting at sp0: hold a conflicting jump while busy (R10)
  task automatic runPush(input string req, input logic [2:0] k, input logic [2:0] c,
                         input logic [3:0] f, input logic [15:0] t, input logic [15:0] n,
                         input logic [2:0] r, input logic [15:0] sp0, input logic [15:0] expPc);
    setOp(k, 1'b1, c, f, t, n, 16'h0, r);
    @(posedge clk); @(negedge clk);
    setOp(3'd1, 1'b0, 3'd0, 4'b0, 16'hDEAD, 16'hBEEF, 16'h0, 3'd0);
    chk({req, " R5 busy1"}, busy, 1);
    chk({req, " R5 we1"}, memWe, 1);
    chk({req, " R5 addr1"}, memAddr, sp0 - 16'd1);
    chk({req, " R5 data hi"}, memWrData, n[15:8]);
    @(posedge clk); @(negedge clk);
    chk({req, " R5 busy2"}, busy, 1);
    chk({req, " R5 addr2"}, memAddr, sp0 - 16'd2);
    chk({req, " R5 data lo"}, memWrData, n[7:0]);
    @(posedge clk); @(negedge clk);
    opValid = 1'b0;
    chk({req, " R6 busy end"}, busy, 0);
    chk({req, " R6 pc (R10 jump ignored)"}, pc, expPc);
    chk({req, " R6 sp"}, sp, sp0 - 16'd2);
  endtask

  task automatic runPop(input string req, input logic [2:0] c, input logic [3:0] f,
                        input logic [15:0] sp0, input logic [15:0] expPc);
    setOp(3'd3, 1'b1, c, f, 16'h0, 16'h2222, 16'h0, 3'd0);
    @(posedge clk); @(negedge clk);
    setOp(3'd5, 1'b0, 3'd0, 4'b0, 16'h0, 16'h0, 16'hCAFE, 3'd0);
    chk({req, " R7 re1"}, memRe, 1);
    chk({req, " R7 addr lo"}, memAddr, sp0);
    @(posedge clk); @(negedge clk);
    chk({req, " R7 addr hi"}, memAddr, sp0 + 16'd1);
    @(posedge clk); @(negedge clk);
    opValid = 1'b0;
    chk({req, " R7 busy end"}, busy, 0);
    chk({req, " R7 pc (R10 H-L jump ignored)"}, pc, expPc);
    chk({req, " R7 sp"}, sp, sp0 + 16'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rstN = 1'b0;
    setOp(3'd2, 1'b0, 3'd0, 4'b0, 16'h3333, 16'h4444, 16'h5555, 3'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", pc, 16'h0000);
    chk("R1 sp in reset", sp, 16'hF000);
    chk("R1 busy in reset", busy, 0);
    chk("R1 strobes in reset", {memWe, memRe}, 0);
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", pc, 16'h0000);
    chk("R1 busy after reset", busy, 0);

    // single-cycle operations from the table (R2, R3, R4, R9)
    for (int i = 0; i < NV; i++) begin
      setOp(VECS[i].kind, VECS[i].uc, VECS[i].cond, VECS[i].flg,
            VECS[i].tgt, VECS[i].nxt, VECS[i].hl, 3'd0);
      @(posedge clk); @(negedge clk);
      opValid = 1'b0;
      chk($sformatf("R3/R4/R9 vector %0d pc", i), pc, VECS[i].exp);
      chk($sformatf("R3 vector %0d no stack", i), {busy, memWe, memRe}, 0);
    end

    // R11: failing conditional call (C with carry clear) and return (Z with zero clear)
    setOp(3'd2, 1'b1, 3'd3, 4'b0000, 16'h8000, 16'h1237, 16'h0, 3'd0);
    @(posedge clk); @(negedge clk);
    opValid = 1'b0;
    chk("R11 call not taken pc", pc, 16'h1237);
    chk("R11 call not taken busy/mem", {busy, memWe, memRe}, 0);
    chk("R11 call not taken sp", sp, 16'hF000);
    setOp(3'd3, 1'b1, 3'd1, 4'b0000, 16'h0, 16'h123A, 16'h0, 3'd0);
    @(posedge clk); @(negedge clk);
    opValid = 1'b0;
    chk("R11 ret not taken pc", pc, 16'h123A);
    chk("R11 ret not taken busy/mem", {busy, memWe, memRe}, 0);
    chk("R11 ret not taken sp", sp, 16'hF000);

    // R5/R6: taken conditional call (PE with parity even)
    runPush("call", 3'd2, 3'd5, 4'b0001, 16'h8000, 16'h1234, 3'd0, 16'hF000, 16'h8000);
    // R8: restart 5 nested below it
    runPush("R8 rst5", 3'd4, 3'd0, 4'b0000, 16'h9999, 16'h8001, 3'd5, 16'hEFFE, 16'h0028);
    // R8: restart 7, the last vector
    runPush("R8 rst7", 3'd4, 3'd0, 4'b0000, 16'h9999, 16'h0029, 3'd7, 16'hEFFC, 16'h0038);
    // R7: unwind three levels (the last one is a conditional NC return, carry clear)
    runPop("ret1", 3'd0, 4'b0000, 16'hEFFA, 16'h0029);
    runPop("ret2", 3'd0, 4'b0000, 16'hEFFC, 16'h8001);
    runPop("ret3 cond", 3'd2, 4'b0000, 16'hEFFE, 16'h1234);

    // R2: idle without opValid holds pc, then step
    @(posedge clk); @(negedge clk);
    chk("R2 hold without opValid", pc, 16'h1234);
    setOp(3'd0, 1'b0, 3'd0, 4'b0, 16'h0, 16'h1235, 16'h0, 3'd0);
    @(posedge clk); @(negedge clk);
    opValid = 1'b0;
    chk("R2 step", pc, 16'h1235);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule